// File: doc/BRIEF.md
# Adder-Subtractor with Magnitude Correction

This block adds or subtracts two unsigned operands. In add mode it returns the full sum: a result word plus a carry bit. In subtract mode it returns the difference in sign-and-magnitude form, so the result is never left in raw two's complement.

A first ripple adder forms `a_i + (b_i ^ sub)` with the mode bit as carry-in. A difference is negative exactly when subtract mode is selected and this adder produces no carry. In that case a second, increment-only stage inverts the raw word and adds one, which turns the two's-complement value back into its magnitude. When the difference is not negative, the second stage passes the word through unchanged.

The block is purely combinational. The carry output always comes from the first adder. It is the fifth result bit in add mode and the "A not below B" indication in subtract mode.

Top module: `addsub_magnitude`

## Requirements
- R1: With `sub_i`=0 (add), `{carry_o, mag_o}` equals `a_i + b_i` as a W+1 bit unsigned value.
- R2: With `sub_i`=0, `neg_o` is 0 for every operand pair.
- R3: With `sub_i`=1 and `a_i` >= `b_i`, `mag_o` equals `a_i - b_i` and `neg_o` is 0.
- R4: With `sub_i`=1 and `a_i` < `b_i`, `mag_o` equals `b_i - a_i` and `neg_o` is 1.
- R5: With `sub_i`=1, `carry_o` is 1 exactly when `a_i` >= `b_i`.
- R6: Subtracting `b_i`=0 gives `mag_o`=`a_i`, `carry_o`=1 and `neg_o`=0.
- R7: Subtracting equal operands gives `mag_o`=0, `carry_o`=1 and `neg_o`=0, with no spurious negative zero.
- R8: The correction stage never supplies the carry output. For example, 1001 + 1000 gives `carry_o`=1 and `mag_o`=0001.
- R9: 1010 minus 1100 gives `mag_o`=0010 with `neg_o`=1 and `carry_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W (4) | First operand, unsigned |
| b_i | input | W (4) | Second operand, unsigned (subtrahend in subtract mode) |
| sub_i | input | 1 | Mode: 0 = add, 1 = a_i minus b_i |
| mag_o | output | W (4) | Sum (add mode) or magnitude of the difference (subtract mode) |
| carry_o | output | 1 | First-stage carry-out: fifth sum bit when adding, a_i >= b_i when subtracting |
| neg_o | output | 1 | Difference is negative; only ever 1 in subtract mode |

## Verification
The bench tries every one of the 256 operand pairs in both modes. This covers sums that overflow into the carry and sums that do not. It also covers differences on both sides of zero, so a wrong negative flag or a skipped re-complement shows up as a wrong magnitude.

Directed vectors add further cases:
- 1001 + 1000 separates the first-stage carry from the carry of the correction stage.
- Subtracting zero and subtracting equal operands separate "no carry" from "negative". A fault there yields a negative zero or a magnitude of 0000 with the flag set.
- The extreme pairs 0-15 and 15-1 exercise the longest carry and borrow chains.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned ADDSUB_W = 4;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_op_e;
endpackage

// File: rtl/addsub_full_adder.sv
module addsub_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ c_i;
  assign c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar g = 0; g < W; g++) begin : g_bit
    addsub_full_adder i_fa (
      .x_i (x_i[g]),
      .y_i (y_i[g]),
      .c_i (chain[g]),
      .s_o (sum_o[g]),
      .c_o (chain[g+1])
    );
  end

  assign cout_o = chain[W];
endmodule

// File: rtl/addsub_fixup.sv
// Second stage: (raw ^ {W{fix}}) + 0 + fix, i.e. a conditional two's complement.
// Its final carry is never built, so it cannot leak to the carry output.
module addsub_fixup #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] raw_i,
  input  logic         fix_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] inv;
  logic [W-1:0] carry;

  assign inv = raw_i ^ {W{fix_i}};

  always_comb begin
    carry[0] = fix_i;
    for (int k = 1; k < W; k++) begin
      carry[k] = inv[k-1] & carry[k-1];
    end
  end

  assign res_o = inv ^ carry;
endmodule

// File: rtl/addsub_magnitude.sv
module addsub_magnitude
  import addsub_pkg::*;
#(
  parameter int unsigned W = ADDSUB_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] mag_o,
  output logic         carry_o,
  output logic         neg_o
);
  addsub_op_e op;
  logic       is_sub;
  logic [W-1:0] b_cond;
  logic [W-1:0] raw_sum;
  logic         raw_cout;

  assign op     = addsub_op_e'(sub_i);
  assign is_sub = (op == OP_SUB);
  assign b_cond = b_i ^ {W{is_sub}};

  addsub_ripple #(.W(W)) i_stage1 (
    .x_i    (a_i),
    .y_i    (b_cond),
    .cin_i  (is_sub),
    .sum_o  (raw_sum),
    .cout_o (raw_cout)
  );

  // No carry while subtracting means the result wrapped below zero.
  assign neg_o = is_sub & ~raw_cout;

  addsub_fixup #(.W(W)) i_stage2 (
    .raw_i (raw_sum),
    .fix_i (neg_o),
    .res_o (mag_o)
  );

  assign carry_o = raw_cout;
endmodule

// File: rtl/addsub_magnitude_chk.sv
module addsub_magnitude_chk #(
  parameter int unsigned W = 4
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         sub_i,
  input logic [W-1:0] mag_o,
  input logic         carry_o,
  input logic         neg_o
);
  logic [W:0] ref_sum;
  logic       a_ge_b;

  assign ref_sum = {1'b0, a_i} + {1'b0, b_i};
  assign a_ge_b  = (a_i >= b_i);

  always_comb begin
    if (!sub_i) begin
      a_r1_full_sum: assert ({carry_o, mag_o} == ref_sum);
      a_r2_no_neg_in_add: assert (!neg_o);
    end else begin
      a_r5_carry_is_ge: assert (carry_o == a_ge_b);
      if (a_ge_b) begin
        a_r3_pos_diff: assert ((mag_o == W'(a_i - b_i)) && !neg_o);
      end else begin
        a_r4_neg_mag: assert ((mag_o == W'(b_i - a_i)) && neg_o);
      end
    end
  end
endmodule

bind addsub_magnitude addsub_magnitude_chk #(.W(W)) i_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .sub_i   (sub_i),
  .mag_o   (mag_o),
  .carry_o (carry_o),
  .neg_o   (neg_o)
);

// File: tb/test_addsub_magnitude.sv
module test_addsub_magnitude;
  localparam int unsigned W = 4;
  localparam int unsigned N_DIR = 8;
  localparam int unsigned WATCHDOG = 200000;

  logic clk;
  logic rst_n;
  logic [W-1:0] a, b, mag;
  logic sub, carry, neg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // {sub, a, b, exp_carry, exp_neg, exp_mag}
  localparam logic [14:0] VEC [N_DIR] = '{
    {1'b0, 4'd9,  4'd8,  1'b1, 1'b0, 4'd1 },  // R8
    {1'b1, 4'd10, 4'd12, 1'b0, 1'b1, 4'd2 },  // R9
    {1'b1, 4'd7,  4'd0,  1'b1, 1'b0, 4'd7 },  // R6
    {1'b1, 4'd5,  4'd5,  1'b1, 1'b0, 4'd0 },  // R7
    {1'b0, 4'd15, 4'd15, 1'b1, 1'b0, 4'd14},  // R1
    {1'b0, 4'd3,  4'd4,  1'b0, 1'b0, 4'd7 },  // R1
    {1'b1, 4'd0,  4'd15, 1'b0, 1'b1, 4'd15},  // R4
    {1'b1, 4'd15, 4'd1,  1'b1, 1'b0, 4'd14}   // R3
  };
  localparam string VEC_TAG [N_DIR] = '{"R8", "R9", "R6", "R7", "R1", "R1", "R4", "R3"};

  addsub_magnitude #(.W(W)) i_addsub_magnitude (
    .a_i     (a),
    .b_i     (b),
    .sub_i   (sub),
    .mag_o   (mag),
    .carry_o (carry),
    .neg_o   (neg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic sv);
    @(negedge clk);
    a = av; b = bv; sub = sv;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic ec, input logic en, input logic [W-1:0] em);
    n_checks++;
    if (carry !== ec || neg !== en || mag !== em) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d sub=%0b: got carry=%0b neg=%0b mag=%0d, exp carry=%0b neg=%0b mag=%0d",
               tag, a, b, sub, carry, neg, mag, ec, en, em);
    end
  endtask

  initial begin
    fork
      begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fail++;
          $display("FAIL watchdog: got timeout, exp completion");
          $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; sub = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset-idle", 1'b0, 1'b0, '0);
    rst_n = 1'b1;

    for (int i = 0; i < N_DIR; i++) begin
      apply(VEC[i][13:10], VEC[i][9:6], VEC[i][14]);
      check(VEC_TAG[i], VEC[i][5], VEC[i][4], VEC[i][3:0]);
    end

    for (int s = 0; s < 2; s++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          int diff;
          int total;
          apply(W'(x), W'(y), s[0]);
          if (s == 0) begin
            total = x + y;
            check("R1/R2 add sweep", total >= 16, 1'b0, W'(total % 16));
          end else if (x >= y) begin
            diff = x - y;
            check("R3/R5 sub sweep", 1'b1, 1'b0, W'(diff));
          end else begin
            diff = y - x;
            check("R4/R5 sub sweep", 1'b0, 1'b1, W'(diff));
          end
        end
      end
    end

    apply(4'd12, 4'd0, 1'b1);
    check("R6 minus zero", 1'b1, 1'b0, 4'd12);
    apply(4'd0, 4'd0, 1'b1);
    check("R7 zero minus zero", 1'b1, 1'b0, 4'd0);
    apply(4'd9, 4'd8, 1'b0);
    check("R8 carry from first stage", 1'b1, 1'b0, 4'd1);
    apply(4'd10, 4'd12, 1'b1);
    check("R9 ten minus twelve", 1'b0, 1'b1, 4'd2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule